// File: doc/BRIEF.md
# Banked Circular Data Address Generator

The block generates a data memory address for each access from four sets of registers. Each set has an index, a modify, a length and a base register. An access names one index register and one modify register, which can come from different sets. It can also use an immediate signed offset in place of the modify register. The length and base registers always come from the set with the same number as the chosen index.

A zero length selects plain linear stepping with 16-bit wrap-around. A nonzero length keeps the stepped index inside the circular buffer `[base, base+length)`: the length is subtracted when the sum reaches or passes the buffer end, and added when it falls below the base.

Pre-modify accesses address memory with the stepped value and write it back only when asked. Post-modify accesses address memory with the current index and always write back the stepped value. An 8-bit page register forms the upper byte of the 24-bit address. A second, shadow copy of all sixteen address registers can be made active with a bank select input, so an interrupt handler gets its own pointers while the primary contents stay intact.

Top module: `circ_agu`

## Requirements
- R1: After a synchronous reset, every address register in both banks and the page register read as zero, and `addr_out` is 0.
- R2: A write with `wr_en` stores `wr_data` in the active bank, into the register chosen by `wr_sel` and by `wr_kind`, where 0 is index, 1 is modify, 2 is length and 3 is base. The register is visible on `rd_data` (same kind/select coding) in the next cycle.
- R3: With a length of 0, the stepped value is index plus modify modulo 2^16. The modify value is taken as a signed 16-bit offset.
- R4: With a nonzero length L and base B, when index+modify ≥ B+L the stepped value is index+modify−L. When index+modify < B it is index+modify+L. Otherwise it is the sum. Base and length are those of the selected index number.
- R5: When `acc_pre`=1, `addr_out[15:0]` is the stepped value. The index register takes the stepped value when `acc_upd`=1 and keeps its value when `acc_upd`=0, and `idx_next` shows the value the index will hold.
- R6: When `acc_pre`=0, `addr_out[15:0]` is the current index, and the index register and `idx_next` take the stepped value.
- R7: `addr_out[23:16]` equals the page register, which is loaded from `page_wr_data` on `page_wr_en`.
- R8: With `acc_imm_en`=1 the signed `acc_imm` replaces the selected modify register in the step.
- R9: With `alt_bank`=1 all accesses, writes and reads use the shadow set. The primary set keeps its contents and is used again when `alt_bank` returns to 0.
- R10: If a register write targets the index being updated by an access in the same cycle, the written value is kept.
- R11: Any index register can be stepped with any modify register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_bank | input | 1 | 1 selects the shadow register set |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 base |
| wr_sel | input | 2 | Register number for write |
| wr_data | input | 16 | Write data |
| page_wr_en | input | 1 | Page register write strobe |
| page_wr_data | input | 8 | Page write data |
| rd_kind | input | 2 | Read kind, same coding as `wr_kind` |
| rd_sel | input | 2 | Register number for read |
| rd_data | output | 16 | Read data from active set |
| acc_en | input | 1 | Access strobe |
| acc_isel | input | 2 | Index register number for the access |
| acc_msel | input | 2 | Modify register number for the access |
| acc_pre | input | 1 | 1 pre-modify, 0 post-modify |
| acc_upd | input | 1 | Pre-modify write-back enable |
| acc_imm_en | input | 1 | Use immediate offset instead of modify register |
| acc_imm | input | 16 | Signed immediate offset |
| addr_out | output | 24 | Page and 16-bit effective address |
| idx_next | output | 16 | Index value after this access |

## Verification
On every cycle, the assertions check four things:
- a write lands in its register and wins over a concurrent update;
- an index update stores the stepped value;
- the inactive bank never changes;
- the page byte follows the last page write.

They also check that a circular step whose index and offset start inside the buffer stays inside it. The exact wrap arithmetic at both buffer edges, and the hold of an index on pre-modify without write-back, are shown by the bench's scenarios. So are immediate offsets and the return to primary contents after a shadow-bank episode. The bench compares against a register-level model on every cycle.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
    localparam int AGU_AW    = 16;
    localparam int AGU_PW    = 8;
    localparam int AGU_NSET  = 4;
    localparam int AGU_NBANK = 2;

    typedef enum logic [1:0] {
        RK_INDEX  = 2'd0,
        RK_MODIFY = 2'd1,
        RK_LENGTH = 2'd2,
        RK_BASE   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [AGU_AW-1:0] idx;
        logic [AGU_AW-1:0] mod;
        logic [AGU_AW-1:0] len;
        logic [AGU_AW-1:0] base;
    } step_in_t;

    function automatic logic [AGU_AW+1:0] zext2(input logic [AGU_AW-1:0] v);
        return {2'b00, v};
    endfunction

    function automatic logic [AGU_AW+1:0] sext2(input logic [AGU_AW-1:0] v);
        return {{2{v[AGU_AW-1]}}, v};
    endfunction
endpackage

// File: rtl/agu_step.sv
module agu_step
    import circ_agu_pkg::*;
#(
    parameter int AW = AGU_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  step_in_t      s_in,
    output logic [AW-1:0] stepped
);
    localparam int XW = AW + 2;

    logic signed [XW-1:0] sum_s, base_s, end_s, len_s;
    logic signed [XW-1:0] res_s;

    always_comb begin
        sum_s  = $signed(zext2(s_in.idx)) + $signed(sext2(s_in.mod));
        base_s = $signed(zext2(s_in.base));
        len_s  = $signed(zext2(s_in.len));
        end_s  = base_s + len_s;
        if (s_in.len == '0)
            res_s = sum_s;
        else if (sum_s >= end_s)
            res_s = sum_s - len_s;
        else if (sum_s < base_s)
            res_s = sum_s + len_s;
        else
            res_s = sum_s;
        stepped = res_s[AW-1:0];
    end

    // R4: a legal circular step starting inside the buffer stays in it
    logic [AW-1:0] mod_mag;
    logic          legal_circ;
    assign mod_mag    = s_in.mod[AW-1] ? (~s_in.mod + 1'b1) : s_in.mod;
    assign legal_circ = (s_in.len != '0) && (mod_mag <= s_in.len)
                      && ($signed(zext2(s_in.idx)) >= base_s)
                      && ($signed(zext2(s_in.idx)) < end_s)
                      && (end_s <= $signed(zext2('1) + 1));

    a_r4_stays_in_buffer: assert property (@(posedge clk) disable iff (rst)
        legal_circ |-> (($signed(zext2(stepped)) >= base_s) && ($signed(zext2(stepped)) < end_s)));
endmodule

// File: rtl/agu_regbank.sv
module agu_regbank
    import circ_agu_pkg::*;
#(
    parameter int AW    = AGU_AW,
    parameter int NSET  = AGU_NSET,
    parameter int NBANK = AGU_NBANK
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bank,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NSET)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    upd_en,
    input  logic [$clog2(NSET)-1:0] upd_sel,
    input  logic [AW-1:0]           upd_val,
    input  logic [1:0]              rd_kind,
    input  logic [$clog2(NSET)-1:0] rd_sel,
    output logic [AW-1:0]           rd_data,
    input  logic [$clog2(NSET)-1:0] isel,
    input  logic [$clog2(NSET)-1:0] msel,
    output step_in_t                regs_out
);
    localparam int NKIND = 4;

    logic [AW-1:0] regs_q [NBANK][NKIND][NSET];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++)
                for (int k = 0; k < NKIND; k++)
                    for (int s = 0; s < NSET; s++)
                        regs_q[b][k][s] <= '0;
        end else begin
            if (upd_en)
                regs_q[bank][RK_INDEX][upd_sel] <= upd_val;
            if (wr_en)   // R10: placed after the update so it wins
                regs_q[bank][wr_kind][wr_sel] <= wr_data;
        end
    end

    assign rd_data       = regs_q[bank][rd_kind][rd_sel];
    assign regs_out.idx  = regs_q[bank][RK_INDEX][isel];
    assign regs_out.mod  = regs_q[bank][RK_MODIFY][msel];
    assign regs_out.len  = regs_q[bank][RK_LENGTH][isel];
    assign regs_out.base = regs_q[bank][RK_BASE][isel];

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        for (genvar gk = 0; gk < NKIND; gk++) begin : g_kind
            for (genvar gs = 0; gs < NSET; gs++) begin : g_sel
                // R9: the inactive set is never disturbed
                a_r9_idle_bank_stable: assert property (@(posedge clk) disable iff (rst)
                    (bank != gb) |=> $stable(regs_q[gb][gk][gs]));
                // R2 / R10: a write lands, even over a concurrent update
                a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
                    (wr_en && bank == gb && wr_kind == gk && wr_sel == gs)
                    |=> regs_q[gb][gk][gs] == $past(wr_data));
            end
            // R5 / R6: an unobstructed index update stores the stepped value
            if (gk == 0) begin : g_upd
                for (genvar gs = 0; gs < NSET; gs++) begin : g_u
                    a_r6_update_stored: assert property (@(posedge clk) disable iff (rst)
                        (upd_en && bank == gb && upd_sel == gs
                         && !(wr_en && wr_kind == RK_INDEX && wr_sel == gs))
                        |=> regs_q[gb][0][gs] == $past(upd_val));
                end
            end
        end
    end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
    import circ_agu_pkg::*;
#(
    parameter int AW   = AGU_AW,
    parameter int PW   = AGU_PW,
    parameter int NSET = AGU_NSET
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alt_bank,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NSET)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    page_wr_en,
    input  logic [PW-1:0]           page_wr_data,
    input  logic [1:0]              rd_kind,
    input  logic [$clog2(NSET)-1:0] rd_sel,
    output logic [AW-1:0]           rd_data,
    input  logic                    acc_en,
    input  logic [$clog2(NSET)-1:0] acc_isel,
    input  logic [$clog2(NSET)-1:0] acc_msel,
    input  logic                    acc_pre,
    input  logic                    acc_upd,
    input  logic                    acc_imm_en,
    input  logic [AW-1:0]           acc_imm,
    output logic [PW+AW-1:0]        addr_out,
    output logic [AW-1:0]           idx_next
);
    step_in_t      regs_sel;
    step_in_t      step_req;
    logic [AW-1:0] stepped;
    logic [AW-1:0] ea;
    logic [PW-1:0] page_q;
    logic          upd_en;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (page_wr_en)
            page_q <= page_wr_data;
    end

    agu_regbank #(.AW(AW), .NSET(NSET)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .bank     (alt_bank),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .upd_en   (upd_en),
        .upd_sel  (acc_isel),
        .upd_val  (stepped),
        .rd_kind  (rd_kind),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .isel     (acc_isel),
        .msel     (acc_msel),
        .regs_out (regs_sel)
    );

    always_comb begin
        step_req     = regs_sel;
        step_req.mod = acc_imm_en ? acc_imm : regs_sel.mod;
    end

    agu_step #(.AW(AW)) u_step (
        .clk     (clk),
        .rst     (rst),
        .s_in    (step_req),
        .stepped (stepped)
    );

    always_comb begin
        ea       = acc_pre ? stepped : regs_sel.idx;
        upd_en   = acc_en && !(acc_pre && !acc_upd);
        idx_next = upd_en ? stepped : regs_sel.idx;
        addr_out = {page_q, ea};
    end

    // R7: page byte follows the most recent page write
    a_r7_page_on_top: assert property (@(posedge clk) disable iff (rst)
        $past(page_wr_en && !rst) |-> addr_out[AW+PW-1:AW] == $past(page_wr_data));
endmodule

// File: tb/circ_agu_bench.sv
module circ_agu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        alt_bank, wr_en, page_wr_en, acc_en, acc_pre, acc_upd, acc_imm_en;
    logic [1:0]  wr_kind, wr_sel, rd_kind, rd_sel, acc_isel, acc_msel;
    logic [15:0] wr_data, acc_imm, rd_data, idx_next;
    logic [7:0]  page_wr_data;
    logic [23:0] addr_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m_reg [2][4][4];
    logic [7:0]  m_page;

    always #10 clk = ~clk;

    circ_agu u_circ_agu (
        .clk(clk), .rst(rst), .alt_bank(alt_bank),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
        .page_wr_en(page_wr_en), .page_wr_data(page_wr_data),
        .rd_kind(rd_kind), .rd_sel(rd_sel), .rd_data(rd_data),
        .acc_en(acc_en), .acc_isel(acc_isel), .acc_msel(acc_msel),
        .acc_pre(acc_pre), .acc_upd(acc_upd), .acc_imm_en(acc_imm_en),
        .acc_imm(acc_imm), .addr_out(addr_out), .idx_next(idx_next)
    );

    function automatic logic [15:0] exp_step(input logic [15:0] i, m, b, l);
        int s, e;
        s = int'(i) + int'($signed(m));
        e = int'(b) + int'(l);
        if (l != 0) begin
            if (s >= e) s = s - int'(l);
            else if (s < int'(b)) s = s + int'(l);
        end
        return s[15:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; page_wr_en = 0; acc_en = 0; acc_pre = 0; acc_upd = 0;
        acc_imm_en = 0; acc_imm = 0; wr_kind = 0; wr_sel = 0; wr_data = 0;
        page_wr_data = 0; acc_isel = 0; acc_msel = 0;
    endtask

    // check outputs against the model, then advance one clock and the model
    task automatic tick(input string req);
        logic        b;
        logic [15:0] i, m, st, e_addr, e_next;
        b  = alt_bank;
        i  = m_reg[b][0][acc_isel];
        m  = acc_imm_en ? acc_imm : m_reg[b][1][acc_msel];
        st = exp_step(i, m, m_reg[b][3][acc_isel], m_reg[b][2][acc_isel]);
        e_addr = acc_pre ? st : i;
        e_next = (acc_en && !(acc_pre && !acc_upd)) ? st : i;
        #5;
        chk({req, " addr"}, {8'h0, addr_out}, {8'h0, m_page, e_addr});
        if (acc_en) chk({req, " idx_next"}, {16'h0, idx_next}, {16'h0, e_next});
        chk({req, " rd_data"}, {16'h0, rd_data}, {16'h0, m_reg[b][rd_kind][rd_sel]});
        @(posedge clk);
        if (acc_en && !(acc_pre && !acc_upd)) m_reg[b][0][acc_isel] = st;
        if (wr_en) m_reg[b][wr_kind][wr_sel] = wr_data;
        if (page_wr_en) m_page = page_wr_data;
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] k, input logic [1:0] s, input logic [15:0] d);
        idle();
        wr_en = 1; wr_kind = k; wr_sel = s; wr_data = d;
        rd_kind = k; rd_sel = s;
        tick("R2 write");
        idle();
        tick("R2 readback");
    endtask

    task automatic access(input string req, input logic [1:0] is, input logic [1:0] ms,
                          input logic pre, input logic upd);
        idle();
        acc_en = 1; acc_isel = is; acc_msel = ms; acc_pre = pre; acc_upd = upd;
        rd_kind = 0; rd_sel = is;
        tick(req);
        idle();
        tick({req, " index after"});
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 4; s++) m_reg[b][k][s] = 16'h0;
        m_page = 8'h0;
        idle(); alt_bank = 0; rd_kind = 0; rd_sel = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, all registers of both banks
        for (int b = 0; b < 2; b++) begin
            alt_bank = b[0];
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 4; s++) begin
                    rd_kind = k[1:0]; rd_sel = s[1:0];
                    tick("R1 reset");
                end
        end
        alt_bank = 0;
        // R2, R3, R6: linear post-modify
        wreg(0, 0, 16'h0100); wreg(1, 0, 16'h0003);
        access("R6 post linear", 0, 0, 0, 0);
        // R3: 16-bit wrap in linear mode
        wreg(0, 2, 16'hFFFF); wreg(1, 2, 16'h0001);
        access("R3 linear wrap", 2, 2, 1, 1);
        // R4: circular wrap at the top
        wreg(0, 1, 16'h0205); wreg(3, 1, 16'h0200); wreg(2, 1, 16'h0006);
        wreg(1, 1, 16'h0002); wreg(1, 3, 16'hFFFE);
        access("R4 wrap top", 1, 1, 1, 1);
        // R4 + R11: circular wrap at the bottom using modify set 3
        access("R11 R4 wrap bottom", 1, 3, 1, 1);
        // R5: pre-modify without write-back keeps index
        access("R5 pre no update", 1, 1, 1, 0);
        // R8: immediate offset
        idle(); acc_en = 1; acc_isel = 0; acc_pre = 1; acc_upd = 1;
        acc_imm_en = 1; acc_imm = 16'h0005; rd_kind = 0; rd_sel = 0;
        tick("R8 immediate");
        idle(); tick("R8 index after");
        // R7: page register
        idle(); page_wr_en = 1; page_wr_data = 8'hA5; tick("R7 page write");
        idle(); tick("R7 page on address");
        // R9: shadow bank
        alt_bank = 1; rd_kind = 0; rd_sel = 0; tick("R9 shadow empty");
        wreg(0, 0, 16'h0050);
        access("R9 shadow access", 0, 0, 0, 0);
        alt_bank = 0; rd_kind = 0; rd_sel = 0; tick("R9 primary kept");
        // R10: write beats update
        idle(); acc_en = 1; acc_isel = 0; acc_msel = 0; acc_pre = 0;
        wr_en = 1; wr_kind = 0; wr_sel = 0; wr_data = 16'h0777;
        rd_kind = 0; rd_sel = 0;
        tick("R10 collide");
        idle(); tick("R10 write kept");
        // random mix covering R2..R11
        for (int n = 0; n < 600; n++) begin
            idle();
            alt_bank = ($urandom % 8) == 0;
            rd_kind = 2'($urandom); rd_sel = 2'($urandom);
            if (($urandom % 3) == 0) begin
                wr_en = 1; wr_kind = 2'($urandom); wr_sel = 2'($urandom);
                case (wr_kind)
                    2'd1:    wr_data = 16'($signed(int'($urandom % 17) - 8));
                    2'd2:    wr_data = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom % 12 + 8);
                    2'd3:    wr_data = 16'($urandom % 16'h0400);
                    default: wr_data = 16'($urandom % 16'h0420);
                endcase
            end
            if (($urandom % 10) == 0) begin
                page_wr_en = 1; page_wr_data = 8'($urandom);
            end
            acc_en = ($urandom % 4) != 0;
            acc_isel = 2'($urandom); acc_msel = 2'($urandom);
            acc_pre = 1'($urandom); acc_upd = 1'($urandom);
            acc_imm_en = ($urandom % 5) == 0;
            acc_imm = 16'($signed(int'($urandom % 13) - 6));
            tick("R4 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule